// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Engine

This block is the execution core of a small stack machine with 16-bit words. Each cycle it can take one instruction, marked by a valid strobe. The instruction is one of four kinds: push an external operand, drop the top entry, combine the two top entries arithmetically, or an unassigned code. Arithmetic instructions name no operands. They read the two topmost entries of an internal hardware stack, remove both, and put one result in their place, so the depth falls by one.

The surrounding sequencer drives the instruction stream. It reads back the top-of-stack value and the current depth. Two sticky error flags report rejected instructions. A push that would overflow the stack, or an instruction that would pop more entries than exist, leaves the stack untouched and raises the matching flag. Only a synchronous reset clears the flags.

Top module: `stack_engine`

## Requirements
- R1: After a synchronous reset the depth is 0, the top-of-stack output is 0, and both error flags are 0.
- R2: A push (opcode 3'd0) with valid high raises the depth by one, and from the next cycle the top of stack equals the pushed operand.
- R3: A pop (opcode 3'd1) on a non-empty stack lowers the depth by one, and the entry below becomes the top.
- R4: ADD (opcode 3'd2) replaces the two top entries with their sum modulo 2^16.
- R5: SUB (opcode 3'd3) replaces the two top entries with the second entry minus the top entry, modulo 2^16.
- R6: MUL (opcode 3'd4) replaces the two top entries with the low 16 bits of their product.
- R7: AND (opcode 3'd5) replaces the two top entries with their bitwise AND.
- R8: The stack holds 8 entries. A push at depth 8 is rejected: depth and contents stay the same and the overflow flag is set.
- R9: An arithmetic instruction at depth below 2, or a pop at depth 0, is rejected: depth and contents stay the same and the underflow flag is set.
- R10: Once set, either error flag stays set until reset, whatever instructions follow.
- R11: With valid low, or with an unassigned opcode (3'd6, 3'd7), the stack and flags do not change.
- R12: Every accepted instruction takes effect in the clock cycle it is presented. The top-of-stack output reads 0 whenever the depth is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Instruction present this cycle |
| instOp | input | 3 | Opcode: 0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 and |
| instData | input | 16 | Operand for push; ignored otherwise |
| tosValue | output | 16 | Current top-of-stack entry, 0 when empty |
| stackDepth | output | 4 | Number of occupied entries, 0 to 8 |
| overflowErr | output | 1 | Sticky: a push was refused on a full stack |
| underflowErr | output | 1 | Sticky: a pop or operation lacked entries |

## Verification
The assertions treat instOp and instData as meaningful only while instValid is high, and they assume reset is held for at least one clock before any instruction is checked. The bench meets both conditions. It changes inputs only on the falling edge, drops valid between instructions, and pulses reset for two cycles before each group of directed tests. Rejection cases are reached on purpose: a ninth push, arithmetic with zero or one entry, and a pop at depth zero. In each case the bench checks the depth and top value afterwards, so an illegal instruction that changed the stack would be seen.

// File: rtl/stack_pkg.sv
package stack_pkg;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_AND  = 3'd5
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2,
    ALU_AND = 2'd3
  } alu_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic arith;
    alu_e aluSel;
  } strobe_t;

endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int STACK_DEPTH = 8,
  localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  input  logic [2:0]       instOp,
  input  logic [CNT_W-1:0] depth,
  output strobe_t          strobe,
  output logic             overflowErr,
  output logic             underflowErr
);

  logic isFull, isEmpty, hasPair;
  logic wantPush, wantPop, wantArith;
  alu_e aluSel;

  assign isFull  = (depth == CNT_W'(STACK_DEPTH));
  assign isEmpty = (depth == '0);
  assign hasPair = (depth >= CNT_W'(2));

  always_comb begin
    wantPush  = 1'b0;
    wantPop   = 1'b0;
    wantArith = 1'b0;
    aluSel    = ALU_ADD;
    if (instValid) begin
      case (instOp)
        OP_PUSH: wantPush = 1'b1;
        OP_POP:  wantPop  = 1'b1;
        OP_ADD:  begin wantArith = 1'b1; aluSel = ALU_ADD; end
        OP_SUB:  begin wantArith = 1'b1; aluSel = ALU_SUB; end
        OP_MUL:  begin wantArith = 1'b1; aluSel = ALU_MUL; end
        OP_AND:  begin wantArith = 1'b1; aluSel = ALU_AND; end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.push   = wantPush  && !isFull;
    strobe.pop    = wantPop   && !isEmpty;
    strobe.arith  = wantArith && hasPair;
    strobe.aluSel = aluSel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      if (wantPush && isFull) overflowErr <= 1'b1;
      if ((wantPop && isEmpty) || (wantArith && !hasPair)) underflowErr <= 1'b1;
    end
  end

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflowErr |=> overflowErr);
  a_r10_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    underflowErr |=> underflowErr);
  a_r9_empty_pop_flags: assert property (@(posedge clk) disable iff (rst)
    (instValid && instOp == 3'd1 && depth == '0) |=> underflowErr);
  a_r8_full_push_flags: assert property (@(posedge clk) disable iff (rst)
    (instValid && instOp == 3'd0 && depth == CNT_W'(STACK_DEPTH)) |=> overflowErr);

endmodule

// File: rtl/stack_dp.sv
module stack_dp
  import stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STACK_DEPTH = 8,
  localparam int CNT_W = $clog2(STACK_DEPTH + 1),
  localparam int PTR_W = $clog2(STACK_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] topVal,
  output logic [CNT_W-1:0]  depth
);

  logic [DATA_W-1:0] stackMem [STACK_DEPTH];
  logic [DATA_W-1:0] secVal, aluRes;
  logic [PTR_W-1:0]  topPtr, secPtr, pushPtr;

  assign topPtr  = PTR_W'(depth - CNT_W'(1));
  assign secPtr  = PTR_W'(depth - CNT_W'(2));
  assign pushPtr = PTR_W'(depth);

  assign topVal = (depth != '0) ? stackMem[topPtr] : '0;
  assign secVal = (depth >= CNT_W'(2)) ? stackMem[secPtr] : '0;

  always_comb begin
    case (strobe.aluSel)
      ALU_ADD: aluRes = secVal + topVal;
      ALU_SUB: aluRes = secVal - topVal;
      ALU_MUL: aluRes = secVal * topVal;
      default: aluRes = secVal & topVal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.push)       stackMem[pushPtr] <= pushData;
    else if (strobe.arith) stackMem[secPtr]  <= aluRes;
  end

  always_ff @(posedge clk) begin
    if (rst)                             depth <= '0;
    else if (strobe.push)                depth <= depth + CNT_W'(1);
    else if (strobe.pop || strobe.arith) depth <= depth - CNT_W'(1);
  end

  a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(STACK_DEPTH));
  a_r8_push_has_room: assert property (@(posedge clk) disable iff (rst)
    strobe.push |-> depth < CNT_W'(STACK_DEPTH));
  a_r9_arith_has_pair: assert property (@(posedge clk) disable iff (rst)
    strobe.arith |-> depth >= CNT_W'(2));
  a_r3_pop_has_entry: assert property (@(posedge clk) disable iff (rst)
    strobe.pop |-> depth != '0);
  a_r2_push_grows: assert property (@(posedge clk) disable iff (rst)
    strobe.push |=> (depth == $past(depth) + CNT_W'(1) && topVal == $past(pushData)));
  a_r4_arith_shrinks: assert property (@(posedge clk) disable iff (rst)
    (strobe.arith || strobe.pop) |=> depth == $past(depth) - CNT_W'(1));
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !(strobe.push || strobe.pop || strobe.arith) |=> ($stable(depth) && $stable(topVal)));
  a_r12_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (depth == '0) |-> topVal == '0);

endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STACK_DEPTH = 8,
  localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [2:0]        instOp,
  input  logic [DATA_W-1:0] instData,
  output logic [DATA_W-1:0] tosValue,
  output logic [CNT_W-1:0]  stackDepth,
  output logic              overflowErr,
  output logic              underflowErr
);

  strobe_t strobe;

  stack_ctrl #(.STACK_DEPTH(STACK_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .instValid(instValid), .instOp(instOp),
    .depth(stackDepth), .strobe(strobe),
    .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  stack_dp #(.DATA_W(DATA_W), .STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .pushData(instData),
    .topVal(tosValue), .depth(stackDepth)
  );

endmodule

// File: tb/stack_engine_bench.sv
module stack_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0;
  logic [2:0]  instOp = 3'd0;
  logic [15:0] instData = 16'd0;
  logic [15:0] tosValue;
  logic [3:0]  stackDepth;
  logic        overflowErr, underflowErr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_engine u_stack_engine (
    .clk(clk), .rst(rst), .instValid(instValid), .instOp(instOp),
    .instData(instData), .tosValue(tosValue), .stackDepth(stackDepth),
    .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  // {opcode, operand, expected depth, expected top}
  localparam logic [38:0] VECS [NVEC] = '{
    {3'd0, 16'h0005, 4'd1, 16'h0005},  // R2
    {3'd0, 16'h0003, 4'd2, 16'h0003},  // R2
    {3'd3, 16'h0000, 4'd1, 16'h0002},  // R5 5-3
    {3'd0, 16'h0007, 4'd2, 16'h0007},
    {3'd4, 16'h0000, 4'd1, 16'h000E},  // R6 2*7
    {3'd0, 16'h00FF, 4'd2, 16'h00FF},
    {3'd5, 16'h0000, 4'd1, 16'h000E},  // R7
    {3'd0, 16'hFFF0, 4'd2, 16'hFFF0},
    {3'd2, 16'h0000, 4'd1, 16'hFFFE},  // R4
    {3'd0, 16'h0001, 4'd2, 16'h0001},
    {3'd3, 16'h0000, 4'd1, 16'hFFFD},  // R5
    {3'd0, 16'h0003, 4'd2, 16'h0003},
    {3'd0, 16'h0005, 4'd3, 16'h0005},
    {3'd3, 16'h0000, 4'd2, 16'hFFFE},  // R5 3-5 wraps
    {3'd4, 16'h0000, 4'd1, 16'h0006},  // R6 (-3)*(-2)
    {3'd0, 16'h1234, 4'd2, 16'h1234},
    {3'd0, 16'h0100, 4'd3, 16'h0100},
    {3'd4, 16'h0000, 4'd2, 16'h3400},  // R6 low half
    {3'd0, 16'hFFFF, 4'd3, 16'hFFFF},
    {3'd0, 16'h0001, 4'd4, 16'h0001},
    {3'd2, 16'h0000, 4'd3, 16'h0000},  // R4 wrap
    {3'd1, 16'h0000, 4'd2, 16'h3400}   // R3
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag, input logic [3:0] d, input logic [15:0] t,
                            input logic ovf, input logic unf);
    check({tag, " depth"}, {12'd0, stackDepth}, {12'd0, d});
    check({tag, " tos"}, tosValue, t);
    check({tag, " ovf"}, {15'd0, overflowErr}, {15'd0, ovf});
    check({tag, " unf"}, {15'd0, underflowErr}, {15'd0, unf});
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] data, input logic v = 1'b1);
    @(negedge clk);
    instValid = v; instOp = op; instData = data;
    @(negedge clk);
    instValid = 1'b0; instData = 16'hDEAD;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    doReset();
    checkState("R1 reset", 4'd0, 16'h0000, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i][38:36], VECS[i][35:20]);
      checkState($sformatf("R12 vec%0d", i), VECS[i][19:16], VECS[i][15:0], 1'b0, 1'b0);
    end

    // R11: valid low and unassigned opcodes leave state alone
    issue(3'd0, 16'h4444, 1'b0);
    checkState("R11 valid low", 4'd2, 16'h3400, 1'b0, 1'b0);
    issue(3'd6, 16'h5555);
    checkState("R11 op6", 4'd2, 16'h3400, 1'b0, 1'b0);
    issue(3'd7, 16'h6666);
    checkState("R11 op7", 4'd2, 16'h3400, 1'b0, 1'b0);

    // R9: arithmetic on empty and on a single entry, pop on empty
    doReset();
    issue(3'd2, 16'h0);
    checkState("R9 add empty", 4'd0, 16'h0000, 1'b0, 1'b1);
    doReset();
    issue(3'd0, 16'h0009);
    issue(3'd3, 16'h0);
    checkState("R9 sub one entry", 4'd1, 16'h0009, 1'b0, 1'b1);
    doReset();
    issue(3'd1, 16'h0);
    checkState("R9 pop empty", 4'd0, 16'h0000, 1'b0, 1'b1);
    issue(3'd0, 16'h0042);
    checkState("R10 unf held", 4'd1, 16'h0042, 1'b0, 1'b1);

    // R8: fill to 8, refused ninth push
    doReset();
    for (int k = 1; k <= 8; k++) begin
      issue(3'd0, 16'(k * 16'h11));
      checkState("R8 fill", 4'(k), 16'(k * 16'h11), 1'b0, 1'b0);
    end
    issue(3'd0, 16'h0099);
    checkState("R8 full push", 4'd8, 16'h0088, 1'b1, 1'b0);
    issue(3'd1, 16'h0);
    checkState("R10 ovf held R3", 4'd7, 16'h0077, 1'b1, 1'b0);
    issue(3'd2, 16'h0);
    checkState("R4 after full", 4'd6, 16'h00DD, 1'b1, 1'b0);

    // R1: reset clears flags set earlier
    doReset();
    checkState("R1 reset clears", 4'd0, 16'h0000, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule